// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block sits next to a CPU core and decides which pending request the core services next. There are sixteen priority levels. Level 15 is the reset level. Level 14 is a non-maskable group. Levels 13 down to 0 are maskable. When the core reports an instruction boundary and nothing is already pending, the controller latches the highest requesting level. It then presents that level together with the word address of its vector slot. The choice is held until the core acknowledges it. On acknowledge, a one-hot pulse goes back to the winning source group so the group can clear its flag.

Any reset cause forces the reset level at once, without waiting for a boundary. The reset causes are power-up, the external reset request, watchdog expiry, a flash key violation, and an instruction fetch from the peripheral register region. A reset also clears every enable bit and the global enable. When the core acknowledges the reset level, it also hands over the word it read from the reset vector slot. If that word is the erased pattern, the controller raises a deep-halt command instead of letting execution begin.

A vector slot can be shared by several flags. Each maskable level takes a small group of flags, and each flag has its own enable bit. The level requests when any enabled flag in its group is set. Software finds out which flag fired.

Top module: `intvec_ctrl`

## Requirements
- R1: When several levels request at one boundary, the highest-numbered one is latched (15 beats 14, 14 beats 13, and so on down to 0).
- R2: While `vec_valid` is high, `vec_addr` equals 0xFFE0 plus twice `vec_level`. Reset gives 0xFFFE, level 14 gives 0xFFFC, level 13 gives 0xFFFA, level 5 gives 0xFFEA.
- R3: A power-up reset (`rst_n` low), `rst_pin_req`, `wdt_rst_req` or `key_viol` makes level 15 valid on the next clock edge, or at once for `rst_n`. This happens without a boundary strobe, and it replaces any other level that is pending.
- R4: When `fetch_valid` is high with `fetch_addr` in 0x0000..0x01FF, it acts as a reset cause. A fetch at 0x0200 has no effect.
- R5: Level 14 requests when any `nmi_flags` bit is set together with its enable bit. The enable bits for `nmi_flags[k]` sit at `en_wdata[28+k]`. The global enable has no effect on level 14.
- R6: Maskable level L (0..13) has flags `irq_flags[2L+1:2L]` and enable bits `en_wdata[2L+1:2L]`. It requests only when at least one of its flags is set with its own enable bit, and the global enable is also set.
- R7: Arbitration happens only on a cycle with `insn_bound` high and nothing pending. The latched level and address stay stable until `ack`. While `ack` is high, `ack_grp` has exactly the bit of the latched level set.
- R8: Acknowledging any level below 15 clears the global enable.
- R9: A reset cause clears all enable bits, the global enable and `halt`.
- R10: Acknowledging level 15 with `vec_data` equal to 0xFFFF sets `halt`. `halt` then stays set until the next reset cause. Any other `vec_data` leaves `halt` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| rst_pin_req | input | 1 | External reset request |
| wdt_rst_req | input | 1 | Watchdog expiry reset request |
| key_viol | input | 1 | Flash key violation reset request |
| fetch_valid | input | 1 | An instruction fetch is taking place |
| fetch_addr | input | 16 | Address of that fetch |
| nmi_flags | input | 3 | Non-maskable source flags |
| irq_flags | input | 28 | Maskable flags, two per level |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 31 | New enable bits |
| gie_we | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | New global enable value |
| insn_bound | input | 1 | Instruction boundary strobe |
| ack | input | 1 | Core acknowledges the presented level |
| vec_data | input | 16 | Word read from the vector slot, checked on a level-15 acknowledge |
| vec_valid | output | 1 | A level is pending |
| vec_level | output | 4 | Pending level |
| vec_addr | output | 16 | Vector word address of the pending level |
| ack_grp | output | 16 | One-hot acknowledge to the winning group |
| halt | output | 1 | Deep-halt command |

## Verification
Requests are raised alone, in pairs, and three at once across levels 2, 9 and 13, and then together with the non-maskable group. This shows that the latch follows priority order and not the order of arrival. Each maskable level is tried with the global enable off, with only one flag of a pair enabled, and with a flag arriving while another level is already pending. These cases separate the three gates: the flag's own enable, the global enable, and the hold-until-acknowledge rule. Reset-class stimuli cover each cause once, and fetch addresses on both sides of 0x01FF/0x0200. The reset vector word is given as both erased and programmed, so a wrong halt decision shows up in either direction.

// File: rtl/intvec_ctrl.sv
module intvec_ctrl #(
  parameter int LEVELS = 16,
  parameter int GRP_W  = 2,
  parameter int NMI_W  = 3,
  parameter int AW     = 16,
  parameter logic [AW-1:0] VEC_BASE   = 16'hFFE0,
  parameter logic [AW-1:0] PERIPH_END = 16'h01FF,
  parameter logic [AW-1:0] ERASED     = 16'hFFFF,
  localparam int MASK_LV = LEVELS - 2,
  localparam int MASK_FW = MASK_LV * GRP_W,
  localparam int EN_W    = MASK_FW + NMI_W,
  localparam int LW      = $clog2(LEVELS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_pin_req,
  input  logic               wdt_rst_req,
  input  logic               key_viol,
  input  logic               fetch_valid,
  input  logic [AW-1:0]      fetch_addr,
  input  logic [NMI_W-1:0]   nmi_flags,
  input  logic [MASK_FW-1:0] irq_flags,
  input  logic               en_we,
  input  logic [EN_W-1:0]    en_wdata,
  input  logic               gie_we,
  input  logic               gie_wdata,
  input  logic               insn_bound,
  input  logic               ack,
  input  logic [AW-1:0]      vec_data,
  output logic               vec_valid,
  output logic [LW-1:0]      vec_level,
  output logic [AW-1:0]      vec_addr,
  output logic [LEVELS-1:0]  ack_grp,
  output logic               halt
);
  localparam logic [LW-1:0] RST_LV = LW'(LEVELS - 1);
  localparam logic [LW-1:0] NMI_LV = LW'(LEVELS - 2);

  logic [EN_W-1:0]   en_q;
  logic              gie_q, pend_q, halt_q;
  logic [LW-1:0]     lvl_q, win;
  logic [LEVELS-1:0] lvl_req;
  logic              any_req;

  wire fetch_oor = fetch_valid && (fetch_addr <= PERIPH_END);
  wire rst_req   = rst_pin_req | wdt_rst_req | key_viol | fetch_oor;
  wire accept    = ack & pend_q;
  wire take      = insn_bound & ~pend_q & any_req;

  assign lvl_req[LEVELS-1] = 1'b0;
  assign lvl_req[LEVELS-2] = |(nmi_flags & en_q[MASK_FW +: NMI_W]);

  genvar g;
  generate
    for (g = 0; g < MASK_LV; g++) begin : g_mask
      assign lvl_req[g] = gie_q & (|(irq_flags[g*GRP_W +: GRP_W] & en_q[g*GRP_W +: GRP_W]));
    end
  endgenerate

  always_comb begin
    win = '0;
    for (int i = 0; i < LEVELS; i++)
      if (lvl_req[i]) win = LW'(i);
  end
  assign any_req = |lvl_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      gie_q  <= 1'b0;
      halt_q <= 1'b0;
      pend_q <= 1'b1;
      lvl_q  <= RST_LV;
    end else if (rst_req) begin
      en_q   <= '0;
      gie_q  <= 1'b0;
      halt_q <= 1'b0;
      pend_q <= 1'b1;
      lvl_q  <= RST_LV;
    end else begin
      if (en_we)  en_q  <= en_wdata;
      if (gie_we) gie_q <= gie_wdata;
      if (accept) begin
        pend_q <= 1'b0;
        if (lvl_q == RST_LV) halt_q <= (vec_data == ERASED);
        else                 gie_q  <= 1'b0;
      end else if (take) begin
        pend_q <= 1'b1;
        lvl_q  <= win;
      end
    end
  end

  assign vec_valid = pend_q;
  assign vec_level = lvl_q;
  assign vec_addr  = VEC_BASE + AW'({lvl_q, 1'b0});
  assign ack_grp   = accept ? (LEVELS'(1) << lvl_q) : '0;
  assign halt      = halt_q;

  assert_addr_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr[0] == 1'b0) && (vec_addr >= VEC_BASE));

  assert_reset_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pin_req | wdt_rst_req | key_viol) |=> vec_valid && (vec_level == RST_LV));

  assert_fetch_oor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_addr <= PERIPH_END) |=> vec_valid && (vec_level == RST_LV) && !halt);

  assert_nmi_no_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_bound && !vec_valid && !rst_req && |(nmi_flags & en_q[MASK_FW +: NMI_W]))
    |=> vec_valid && (vec_level == NMI_LV));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !ack && !rst_req) |=> vec_valid && $stable(vec_level));

  assert_ack_grp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_grp != '0) |-> $onehot0(ack_grp) && vec_valid && ack_grp[vec_level]);

  assert_gie_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && vec_valid && vec_level != RST_LV && !rst_req && !gie_we) |=> !gie_q);

  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (en_q == '0) && !gie_q && !halt);

  assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && vec_valid && vec_level == RST_LV && vec_data == ERASED && !rst_req) |=> halt);
endmodule

// File: tb/tb_intvec_ctrl.sv
module tb_intvec_ctrl;
  localparam int CLK_P = 10;
  localparam int EN_W  = 31;

  logic        clk = 0, rst_n = 0;
  logic        rst_pin_req = 0, wdt_rst_req = 0, key_viol = 0;
  logic        fetch_valid = 0;
  logic [15:0] fetch_addr = 16'h8000;
  logic [2:0]  nmi_flags = 0;
  logic [27:0] irq_flags = 0;
  logic        en_we = 0, gie_we = 0, gie_wdata = 0;
  logic [EN_W-1:0] en_wdata = 0;
  logic        insn_bound = 0, ack = 0;
  logic [15:0] vec_data = 16'h4400;
  logic        vec_valid, halt;
  logic [3:0]  vec_level;
  logic [15:0] vec_addr, ack_grp;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  intvec_ctrl dut (
    .clk(clk), .rst_n(rst_n), .rst_pin_req(rst_pin_req), .wdt_rst_req(wdt_rst_req),
    .key_viol(key_viol), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .nmi_flags(nmi_flags), .irq_flags(irq_flags), .en_we(en_we), .en_wdata(en_wdata),
    .gie_we(gie_we), .gie_wdata(gie_wdata), .insn_bound(insn_bound), .ack(ack),
    .vec_data(vec_data), .vec_valid(vec_valid), .vec_level(vec_level),
    .vec_addr(vec_addr), .ack_grp(ack_grp), .halt(halt));

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic chk_vec(input string rq, input int lvl);
    chk(rq, 32'(vec_valid), 1);
    chk(rq, 32'(vec_level), lvl);
    chk(rq, 32'(vec_addr), 32'h0000FFE0 + 2*lvl);
  endtask

  task automatic pulse_bound();
    @(negedge clk) insn_bound = 1;
    @(negedge clk) insn_bound = 0;
  endtask

  task automatic set_en(input logic [EN_W-1:0] v);
    @(negedge clk) begin en_we = 1; en_wdata = v; end
    @(negedge clk) en_we = 0;
  endtask

  task automatic set_gie(input logic b);
    @(negedge clk) begin gie_we = 1; gie_wdata = b; end
    @(negedge clk) gie_we = 0;
  endtask

  task automatic do_ack(input logic [15:0] vd, input int lvl, input string rq);
    @(negedge clk) begin ack = 1; vec_data = vd; end
    #1 chk(rq, 32'(ack_grp), 32'(1) << lvl);
    @(negedge clk) ack = 0;
  endtask

  task automatic t_reset();
    #(CLK_P + 2);
    chk_vec("R3 power-up", 15);
    chk("R10 reset halt", 32'(halt), 0);
    @(negedge clk) rst_n = 1;
    do_ack(16'h4400, 15, "R7 reset ack grp");
    chk("R7 idle after ack", 32'(vec_valid), 0);
    chk("R10 programmed vector", 32'(halt), 0);
  endtask

  task automatic t_gie_gate();
    set_en('1);
    irq_flags = 28'(1) << 10;
    pulse_bound();
    chk("R6 gie off blocks", 32'(vec_valid), 0);
  endtask

  task automatic t_mask_take();
    set_gie(1);
    chk("R7 no boundary yet", 32'(vec_valid), 0);
    pulse_bound();
    chk_vec("R2 R6 level 5", 5);
    do_ack(16'h0, 5, "R7 grp 5");
    pulse_bound();
    chk("R8 gie cleared on accept", 32'(vec_valid), 0);
    irq_flags = 0;
  endtask

  task automatic t_group();
    set_en(EN_W'(1) << 7);
    set_gie(1);
    irq_flags = 28'(1) << 6;
    pulse_bound();
    chk("R6 own enable off", 32'(vec_valid), 0);
    irq_flags = 28'(1) << 7;
    pulse_bound();
    chk_vec("R6 shared slot", 3);
    do_ack(16'h0, 3, "R7 grp 3");
    irq_flags = 0;
  endtask

  task automatic t_priority();
    set_en('1);
    set_gie(1);
    irq_flags = (28'(1) << 4) | (28'(1) << 18) | (28'(1) << 26);
    pulse_bound();
    chk_vec("R1 three-way", 13);
    do_ack(16'h0, 13, "R1 ack 13");
    irq_flags[26] = 0;
    set_gie(1);
    pulse_bound();
    chk_vec("R1 two-way", 9);
    do_ack(16'h0, 9, "R1 ack 9");
    irq_flags[18] = 0;
    irq_flags[26] = 1;
    nmi_flags = 3'b001;
    set_gie(1);
    pulse_bound();
    chk_vec("R1 nmi over 13", 14);
    do_ack(16'h0, 14, "R1 ack 14");
    nmi_flags = 0;
    irq_flags = 0;
  endtask

  task automatic t_nmi();
    set_en('1);
    set_gie(0);
    nmi_flags = 3'b100;
    pulse_bound();
    chk_vec("R5 nmi with gie off", 14);
    do_ack(16'h0, 14, "R5 ack");
    set_en({3'b011, 28'h0});
    pulse_bound();
    chk("R5 own enable off", 32'(vec_valid), 0);
    nmi_flags = 0;
  endtask

  task automatic t_boundary();
    set_en('1);
    set_gie(1);
    irq_flags = 28'(1) << 4;
    repeat (3) @(negedge clk);
    chk("R7 no strobe no take", 32'(vec_valid), 0);
    pulse_bound();
    chk_vec("R7 take lvl 2", 2);
    irq_flags[26] = 1;
    pulse_bound();
    chk_vec("R7 held until ack", 2);
    do_ack(16'h0, 2, "R7 ack goes to 2");
    irq_flags = 0;
  endtask

  task automatic t_oor();
    set_en('1);
    @(negedge clk) begin fetch_valid = 1; fetch_addr = 16'h0200; end
    @(negedge clk) fetch_valid = 0;
    chk("R4 0x0200 harmless", 32'(vec_valid), 0);
    set_gie(1);
    irq_flags = 28'(1) << 10;
    pulse_bound();
    chk_vec("R3 pending before reset", 5);
    irq_flags = 0;
    @(negedge clk) begin fetch_valid = 1; fetch_addr = 16'h01FF; end
    @(negedge clk) fetch_valid = 0;
    chk_vec("R4 R3 fetch 0x01FF", 15);
    do_ack(16'h4400, 15, "R4 ack");
    nmi_flags = 3'b010;
    pulse_bound();
    chk("R9 enables cleared", 32'(vec_valid), 0);
    nmi_flags = 0;
    @(negedge clk) begin fetch_valid = 1; fetch_addr = 16'h0000; end
    @(negedge clk) fetch_valid = 0;
    chk_vec("R4 fetch 0x0000", 15);
    do_ack(16'h4400, 15, "R4 ack 2");
  endtask

  task automatic t_erased();
    @(negedge clk) wdt_rst_req = 1;
    @(negedge clk) wdt_rst_req = 0;
    chk_vec("R3 watchdog", 15);
    do_ack(16'hFFFF, 15, "R10 ack erased");
    chk("R10 halt set", 32'(halt), 1);
    repeat (3) @(negedge clk);
    chk("R10 halt held", 32'(halt), 1);
    @(negedge clk) key_viol = 1;
    @(negedge clk) key_viol = 0;
    chk("R9 halt cleared", 32'(halt), 0);
    chk_vec("R3 key violation", 15);
    do_ack(16'h1234, 15, "R10 ack good");
    chk("R10 no halt", 32'(halt), 0);
    @(negedge clk) rst_pin_req = 1;
    @(negedge clk) rst_pin_req = 0;
    chk_vec("R3 reset pin", 15);
    do_ack(16'h4400, 15, "R3 ack");
  endtask

  initial begin
    t_reset();
    t_gie_gate();
    t_mask_take();
    t_group();
    t_priority();
    t_nmi();
    t_boundary();
    t_oor();
    t_erased();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule